// File: doc/BRIEF.md
# Character Terminal Cursor and Page Controller

This block owns the cursor of a character video terminal and every write into its character RAM. Each page of the screen holds 32 columns by 16 lines, 512 cells in all. The number of pages is a parameter: two by default, and at most sixteen. Received ASCII bytes arrive one at a time with a valid strobe. A printable byte is written into the cell under the cursor, and the cursor then steps forward.

A fixed set of control codes moves the cursor, clears the page on display, or sounds the bell. When the cursor runs past the last cell of a page, it moves to the top of the next page, and the last page wraps back to page 0. The current page index goes to the display logic. The cursor row and column also leave the block, so that a cursor can be drawn.

Clearing a page takes one clock per cell. During the clear the block raises `busy` and takes no new byte. The byte source must hold its byte until `busy` falls.

Top module: `term_cursor_ctrl`

## Requirements
- R1: After reset the cursor is at page 0, row 0, column 0, and `busy`, `wr_en` and `bell` are low.
- R2: A byte is accepted on a clock edge where `in_valid` is high and `busy` is low. An accepted byte in 0x20..0x7E gives a one-cycle `wr_en` in the next cycle. That write carries the byte as `wr_data` and the pre-move cursor as `wr_addr`: column in bits 4:0, row in bits 8:5, page index in the bits above. The cursor then moves one column right.
- R3: A rightward step from column 31 goes to column 0 of the next row. A rightward step from column 31 of row 15 goes to row 0, column 0 of the next page. The page after the last page is page 0.
- R4: Code 0x09 moves the cursor right exactly as a printable byte does, with the same wrapping, and writes nothing.
- R5: Code 0x08 moves the cursor one column left. At column 0 the cursor does not move.
- R6: Code 0x0A moves the cursor down one row and keeps the column. From row 15 it goes to row 0 of the next page. Code 0x0B moves the cursor up one row, and at row 0 the cursor does not move.
- R7: Code 0x0D sets the column to 0 and keeps the row and page. Code 0x1E moves the cursor to row 0, column 0 and keeps the page.
- R8: Code 0x07 drives `bell` high for exactly the one cycle after acceptance. It neither moves the cursor nor writes.
- R9: Code 0x0C puts the cursor at row 0, column 0 of the current page and raises `busy` for exactly 512 cycles. It issues 512 writes of 0x20, one per clock, covering every cell of the current page in ascending address order.
- R10: A byte presented while `busy` is high is not accepted. It changes no cursor position and causes no write.
- R11: Every other code (0x00..0x1F not listed above, 0x7F, and 0x80..0xFF) is accepted and ignored: no write, no bell, no cursor change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received byte is present |
| in_byte | input | 8 | Received ASCII byte |
| busy | output | 1 | Page clear in progress; input is not taken |
| wr_en | output | 1 | Character RAM write strobe |
| wr_addr | output | PAGE_W+9 | Character RAM address {page, row, column} |
| wr_data | output | 8 | Character RAM write data |
| page_idx | output | PAGE_W | Page shown on the display (cursor page) |
| cur_row | output | 4 | Cursor row |
| cur_col | output | 5 | Cursor column |
| bell | output | 1 | One-cycle speaker pulse |

## Verification
The cursor registers reach the ports directly. A wrong move or a missed page wrap therefore shows on `cur_row`, `cur_col` or `page_idx` in the cycle after the byte is accepted. It also shows as a wrong `wr_addr` on the next printable write.

A fault in the clear sequencer shows as a gap, a repeat or a wrong data byte on the write port within the 512-cycle window. A wrong sequencer length shows as a `busy` pulse that is not exactly 512 cycles long. If the stall is broken, a byte presented during a clear leaks out as an extra write, or as a cursor move while `busy` is high.

A scoreboard predicts every write, and any write it did not predict is reported at once.

// File: rtl/term_pkg.sv
package term_pkg;

    localparam int COLS   = 32;
    localparam int ROWS   = 16;
    localparam int COL_W  = $clog2(COLS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int CELLS  = COLS * ROWS;
    localparam int CELL_W = COL_W + ROW_W;

    localparam logic [7:0] CH_BELL  = 8'h07;
    localparam logic [7:0] CH_LEFT  = 8'h08;
    localparam logic [7:0] CH_RIGHT = 8'h09;
    localparam logic [7:0] CH_DOWN  = 8'h0A;
    localparam logic [7:0] CH_UP    = 8'h0B;
    localparam logic [7:0] CH_ERASE = 8'h0C;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_HOME  = 8'h1E;
    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_TILDE = 8'h7E;

    typedef enum logic [3:0] {
        K_NONE, K_PRINT, K_LEFT, K_RIGHT, K_DOWN,
        K_UP, K_ERASE, K_CR, K_HOME, K_BELL
    } cmd_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } pos_t;

    function automatic logic is_printable(input logic [7:0] b);
        return (b >= CH_SPACE) && (b <= CH_TILDE);
    endfunction

endpackage

// File: rtl/term_cmd_decode.sv
module term_cmd_decode
    import term_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cmd
);

    always_comb begin
        if (is_printable(code)) begin
            cmd = K_PRINT;
        end else begin
            case (code)
                CH_BELL:  cmd = K_BELL;
                CH_LEFT:  cmd = K_LEFT;
                CH_RIGHT: cmd = K_RIGHT;
                CH_DOWN:  cmd = K_DOWN;
                CH_UP:    cmd = K_UP;
                CH_ERASE: cmd = K_ERASE;
                CH_CR:    cmd = K_CR;
                CH_HOME:  cmd = K_HOME;
                default:  cmd = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/term_cursor_step.sv
module term_cursor_step
    import term_pkg::*;
#(
    parameter int PAGES  = 2,
    parameter int PAGE_W = 1
) (
    input  logic [PAGE_W-1:0] cur_page,
    input  pos_t              cur_pos,
    input  cmd_e              cmd,
    output logic [PAGE_W-1:0] nxt_page,
    output pos_t              nxt_pos
);

    logic              last_col;
    logic              last_row;
    logic [PAGE_W-1:0] page_inc;

    assign last_col = (cur_pos.col == COL_W'(COLS - 1));
    assign last_row = (cur_pos.row == ROW_W'(ROWS - 1));
    assign page_inc = (cur_page == PAGE_W'(PAGES - 1)) ? '0 : cur_page + PAGE_W'(1);

    always_comb begin
        nxt_page = cur_page;
        nxt_pos  = cur_pos;
        case (cmd)
            K_PRINT, K_RIGHT: begin
                if (!last_col) begin
                    nxt_pos.col = cur_pos.col + COL_W'(1);
                end else begin
                    nxt_pos.col = '0;
                    if (last_row) begin
                        nxt_pos.row = '0;
                        nxt_page    = page_inc;
                    end else begin
                        nxt_pos.row = cur_pos.row + ROW_W'(1);
                    end
                end
            end
            K_LEFT: begin
                if (cur_pos.col != '0) nxt_pos.col = cur_pos.col - COL_W'(1);
            end
            K_DOWN: begin
                if (last_row) begin
                    nxt_pos.row = '0;
                    nxt_page    = page_inc;
                end else begin
                    nxt_pos.row = cur_pos.row + ROW_W'(1);
                end
            end
            K_UP: begin
                if (cur_pos.row != '0) nxt_pos.row = cur_pos.row - ROW_W'(1);
            end
            K_CR:            nxt_pos.col = '0;
            K_HOME, K_ERASE: nxt_pos     = '0;
            default: ;
        endcase
    end

endmodule

// File: rtl/term_erase_seq.sv
module term_erase_seq
    import term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              active,
    output logic [CELL_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            idx <= idx + CELL_W'(1);
            if (idx == CELL_W'(CELLS - 1)) active <= 1'b0;
        end
    end

endmodule

// File: rtl/term_cursor_ctrl.sv
module term_cursor_ctrl
    import term_pkg::*;
#(
    parameter int PAGES = 2,
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int ADDR_W = PAGE_W + CELL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [PAGE_W-1:0] page_idx,
    output logic [ROW_W-1:0]  cur_row,
    output logic [COL_W-1:0]  cur_col,
    output logic              bell
);

    cmd_e              dec_cmd;
    cmd_e              act_cmd;
    logic              accept;
    logic              ers_active;
    logic [CELL_W-1:0] ers_idx;
    pos_t              pos_q;
    pos_t              pos_d;
    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] page_d;

    term_cmd_decode u_dec (
        .code (in_byte),
        .cmd  (dec_cmd)
    );

    assign accept  = in_valid && !ers_active;
    assign act_cmd = accept ? dec_cmd : K_NONE;

    term_cursor_step #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_step (
        .cur_page (page_q),
        .cur_pos  (pos_q),
        .cmd      (act_cmd),
        .nxt_page (page_d),
        .nxt_pos  (pos_d)
    );

    term_erase_seq u_erase (
        .clk    (clk),
        .rst    (rst),
        .start  (act_cmd == K_ERASE),
        .active (ers_active),
        .idx    (ers_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            page_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            bell    <= 1'b0;
        end else begin
            pos_q  <= pos_d;
            page_q <= page_d;
            bell   <= (act_cmd == K_BELL);
            wr_en  <= (act_cmd == K_PRINT) || ers_active;
            if (ers_active) begin
                wr_addr <= {page_q, ers_idx};
                wr_data <= CH_SPACE;
            end else begin
                wr_addr <= {page_q, pos_q};
                wr_data <= in_byte;
            end
        end
    end

    assign busy     = ers_active;
    assign page_idx = page_q;
    assign cur_row  = pos_q.row;
    assign cur_col  = pos_q.col;

endmodule

// File: rtl/term_ctrl_chk.sv
module term_ctrl_chk
    import term_pkg::*;
#(
    parameter int PAGE_W = 1,
    parameter int ADDR_W = PAGE_W + CELL_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        in_byte,
    input logic              busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [PAGE_W-1:0] page_idx,
    input logic [ROW_W-1:0]  cur_row,
    input logic [COL_W-1:0]  cur_col,
    input logic              bell
);

    logic [CELL_W:0] busy_run;
    logic            taken;

    assign taken = in_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) busy_run <= '0;
        else     busy_run <= busy ? busy_run + 1'b1 : '0;
    end

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        taken && in_byte >= 8'h20 && in_byte <= 8'h7E |=>
        wr_en && wr_data == $past(in_byte) &&
        wr_addr == {$past(page_idx), $past(cur_row), $past(cur_col)});

    p_left_edge_r5: assert property (@(posedge clk) disable iff (rst)
        taken && in_byte == 8'h08 && cur_col == '0 |=>
        cur_col == '0 && $stable(cur_row) && $stable(page_idx));

    p_up_edge_r6: assert property (@(posedge clk) disable iff (rst)
        taken && in_byte == 8'h0B && cur_row == '0 |=>
        cur_row == '0 && $stable(cur_col) && $stable(page_idx));

    p_bell_src_r8: assert property (@(posedge clk) disable iff (rst)
        bell |-> $past(taken && in_byte == 8'h07));

    p_erase_data_r9: assert property (@(posedge clk) disable iff (rst)
        busy && wr_en |-> wr_data == 8'h20);

    p_erase_bound_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_run < (CELL_W+1)'(CELLS));

    p_erase_len_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == (CELL_W+1)'(CELLS));

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_row) && $stable(cur_col) && $stable(page_idx));

    p_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        taken && (in_byte == 8'h00 || in_byte == 8'h7F || in_byte[7]) |=>
        !wr_en && !bell && $stable(cur_row) && $stable(cur_col) && $stable(page_idx));

endmodule

bind term_cursor_ctrl term_ctrl_chk #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .busy     (busy),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .page_idx (page_idx),
    .cur_row  (cur_row),
    .cur_col  (cur_col),
    .bell     (bell)
);

// File: tb/test_term_cursor_ctrl.sv
`timescale 1ns/1ps
module test_term_cursor_ctrl;

    localparam int PAGES  = 2;
    localparam int PAGE_W = 1;
    localparam int ADDR_W = PAGE_W + 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_byte = 8'h00;
    logic              busy;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [PAGE_W-1:0] page_idx;
    logic [3:0]        cur_row;
    logic [4:0]        cur_col;
    logic              bell;

    always #2 clk = ~clk;

    term_cursor_ctrl #(.PAGES(PAGES)) i_term_cursor_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_idx(page_idx), .cur_row(cur_row), .cur_col(cur_col), .bell(bell)
    );

    int errs   = 0;
    int checks = 0;
    int m_page = 0;
    int m_row  = 0;
    int m_col  = 0;
    logic [ADDR_W+7:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: every write must match the next predicted one
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R9/R10", "unexpected write addr", int'(wr_addr), -1);
            end else begin
                logic [ADDR_W+7:0] e;
                e = exp_q.pop_front();
                chk({wr_addr, wr_data} == e, "R2/R9", "write {addr,data}",
                    int'({wr_addr, wr_data}), int'(e));
            end
        end
    end

    function automatic void step_right();
        if (m_col < 31) m_col++;
        else begin
            m_col = 0;
            if (m_row < 15) m_row++;
            else begin m_row = 0; m_page = (m_page + 1) % PAGES; end
        end
    endfunction

    function automatic void model(input logic [7:0] b);
        if (b >= 8'h20 && b <= 8'h7E) begin
            exp_q.push_back({ADDR_W'((m_page << 9) | (m_row << 5) | m_col), b});
            step_right();
        end else begin
            case (b)
                8'h09: step_right();
                8'h08: if (m_col > 0) m_col--;
                8'h0A: if (m_row < 15) m_row++;
                       else begin m_row = 0; m_page = (m_page + 1) % PAGES; end
                8'h0B: if (m_row > 0) m_row--;
                8'h0D: m_col = 0;
                8'h1E: begin m_row = 0; m_col = 0; end
                8'h0C: begin
                    m_row = 0; m_col = 0;
                    for (int i = 0; i < 512; i++)
                        exp_q.push_back({ADDR_W'((m_page << 9) | i), 8'h20});
                end
                default: ;
            endcase
        end
    endfunction

    task automatic check_cursor(input string req);
        chk(int'(cur_col) == m_col, req, "cursor column", int'(cur_col), m_col);
        chk(int'(cur_row) == m_row, req, "cursor row", int'(cur_row), m_row);
        chk(int'(page_idx) == m_page, req, "page index", int'(page_idx), m_page);
    endtask

    task automatic send(input logic [7:0] b, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        model(b);
        @(negedge clk);
        in_valid = 1'b0;
        check_cursor(req);
        chk(bell == (b == 8'h07), req, "bell", int'(bell), int'(b == 8'h07));
    endtask

    initial begin
        #400000;
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_cursor("R1");
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(wr_en == 1'b0, "R1", "wr_en", int'(wr_en), 0);
        chk(bell == 1'b0, "R1", "bell", int'(bell), 0);

        // R2 printable writes
        send("H", "R2");
        send("i", "R2");
        // R4 right step
        send(8'h09, "R4");
        // R5 left, clamped at column 0
        send(8'h08, "R5");
        send(8'h08, "R5");
        send(8'h08, "R5");
        send(8'h08, "R5");
        // R6 down / up, up clamped at row 0
        send(8'h0A, "R6");
        send(8'h0B, "R6");
        send(8'h0B, "R6");
        // R7 carriage return and home
        send("A", "R2");
        send("B", "R2");
        send(8'h0D, "R7");
        send(8'h0A, "R6");
        send(8'h0A, "R6");
        send("x", "R2");
        send(8'h1E, "R7");
        // R8 bell pulse, one cycle only
        send(8'h07, "R8");
        @(negedge clk);
        chk(bell == 1'b0, "R8", "bell after one cycle", int'(bell), 0);
        // R11 ignored codes
        send(8'h00, "R11");
        send(8'h1B, "R11");
        send(8'h7F, "R11");
        send(8'h80, "R11");
        send(8'hFF, "R11");
        // R3 end of line
        for (int i = 0; i < 31; i++) send(8'h09, "R4");
        send("Z", "R3");
        // R9 erase, R10 stall during erase
        send(8'h0A, "R6");
        send(8'h0C, "R9");
        begin
            int n = 0;
            while (busy) begin
                n++;
                if (n == 10) begin in_valid = 1'b1; in_byte = "Q"; end
                if (n == 40) in_valid = 1'b0;
                @(negedge clk);
            end
            chk(n == 512, "R9", "busy cycles", n, 512);
        end
        @(negedge clk);
        check_cursor("R10");
        chk(exp_q.size() == 0, "R9", "erase writes left", exp_q.size(), 0);
        // R6 down from last row goes to next page
        for (int i = 0; i < 15; i++) send(8'h0A, "R6");
        send(8'h09, "R4");
        send(8'h0A, "R6");
        send(8'h1E, "R7");
        // R3 whole-page fill: page 1 -> page 0 (wrap) -> page 1
        for (int i = 0; i < 512; i++) send(8'(8'h20 + (i % 95)), "R3");
        check_cursor("R3");
        for (int i = 0; i < 512; i++) send(8'(8'h21 + (i % 90)), "R3");
        check_cursor("R3");
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "predicted writes left", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule